// File: doc/BRIEF.md
# Dual Interval Timer with Identification Window

This block places two identical down-counting interval timers in a single 4 KB register window. A bus master reaches either timer through a simple word-addressed request interface. Each timer has its own count-enable input, so the two counters can advance at unrelated rates. The two per-timer interrupt lines are merged into one level output. The top 32 bytes of the window return a fixed eight-byte identification sequence. Two test-control offsets decode but always read as zero.

Each timer has a load value, a live count and an 8-bit control word. The count decrements on every prescaled tick while the timer is enabled. When the count reaches zero, the timer latches a raw interrupt flag. What happens after zero depends on the mode: periodic reload, free-running wrap, or one-shot stop. Software clears the flag by a write. Reads have no side effects, and the read data is combinational from the request.

Top module: `dual_timer`

## Requirements
- R1: Byte offsets 0x000-0x01F address timer 0. Offsets 0x020-0x03F address timer 1 at the same local offsets (address minus 0x20). Address bits 1:0 are ignored.
- R2: Local map of each timer: 0x00 load (a write also sets the count), 0x04 count (writes ignored), 0x08 control, 0x0C interrupt clear (write any value), 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 background load (updates the load value only, count untouched; reads return the load value). Local offset 0x1C reads zero.
- R3: Control bits: bit 0 one-shot, bit 1 32-bit width (0 = 16-bit), bits 3:2 prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 enable. After reset, control reads 0x20, load reads 0 and count reads 0xFFFFFFFF.
- R4: While enabled, each prescaled tick decrements the count within the selected width. A tick that takes the count from 1 to 0 sets the raw flag.
- R5: A tick with the count at zero does one of three things. If bit 0 is set, the count stays at zero (one-shot has priority). Otherwise, if bit 6 is set, the count reloads the load value. With bits 0 and 6 both clear, the count reloads all ones of the selected width (0xFFFF or 0xFFFFFFFF).
- R6: Prescale code 1 advances the count on every 16th tick, and code 2 on every 256th tick. Codes 0 and 3 advance it on every tick. The prescale phase restarts on every control write.
- R7: Timer 0 advances only on tick0_i and timer 1 only on tick1_i.
- R8: Masked flag = raw flag AND interrupt enable. irq_o is the OR of both masked flags. A clear write drops the raw flag unless a zero-crossing sets it in the same cycle.
- R9: Word reads at 0xFE0, 0xFE4 ... 0xFFC return 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 respectively.
- R10: Reads of 0xF00, 0xF04 and any other unmapped offset return zero. Writes outside 0x000-0x03F change no state.
- R11: With bit 7 clear, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick0_i | input | 1 | Count-enable pulse for timer 0 |
| tick1_i | input | 1 | Count-enable pulse for timer 1 |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested |
| irq_o | output | 1 | Merged interrupt level |

## Verification
The bench targets four kinds of corner case.

- Address decode: it reads timer 1 through the 0x20 offset and writes into the gaps of the window. A decoder that ignored address bit 5 would show timer 0 values at 0x020. A decoder that let far writes through would corrupt a load value.
- Behaviour at zero: it covers all three modes. A one-shot timer that reloaded, or a free-running counter that wrapped to the wrong width, would read back the wrong count.
- Prescaler: it checks the tick just before and the tick on each boundary, which exposes an off-by-one divider.
- Interrupts: it checks the merge with both sources raised, then clears them one at a time. It also checks the masking, which catches an OR of raw flags.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 12;
  localparam int unsigned NT     = 2;
  localparam int unsigned TIDX_W = $clog2(NT);
  localparam int unsigned CW     = 8;
  localparam int unsigned PRE_W  = 8;
  localparam int unsigned SLOT_LSB = 5;              // 32-byte slot per timer
  localparam int unsigned WIN_LSB  = SLOT_LSB + TIDX_W;

  // control bit positions
  localparam int unsigned CB_ONESHOT  = 0;
  localparam int unsigned CB_WIDE     = 1;
  localparam int unsigned CB_PS       = 2;
  localparam int unsigned CB_IE       = 5;
  localparam int unsigned CB_PERIODIC = 6;
  localparam int unsigned CB_EN       = 7;
  localparam logic [CW-1:0] CTRL_RST  = 8'h20;

  typedef enum logic [2:0] {
    REG_LOAD  = 3'd0,
    REG_COUNT = 3'd1,
    REG_CTRL  = 3'd2,
    REG_ICLR  = 3'd3,
    REG_RAW   = 3'd4,
    REG_MSK   = 3'd5,
    REG_BGLD  = 3'd6,
    REG_NONE  = 3'd7
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h04;
      3'd1:    b = 8'h18;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dual_timer_prescaler.sv
module dual_timer_prescaler
  import dual_timer_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  output logic       stick_o
);
  localparam int unsigned D16_BITS  = 4;
  localparam int unsigned D256_BITS = 8;

  logic [PW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + 1'b1;
  end

  always_comb begin
    case (mode_i)
      2'd1:    stick_o = tick_i & (&acc_q[D16_BITS-1:0]);
      2'd2:    stick_o = tick_i & (&acc_q[D256_BITS-1:0]);
      default: stick_o = tick_i;
    endcase
  end
endmodule

// File: rtl/dual_timer_core.sv
module dual_timer_core
  import dual_timer_pkg::*;
#(
  parameter int unsigned DWP = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           wr_i,
  input  reg_sel_e       sel_i,
  input  logic [DWP-1:0] wdata_i,
  output logic [DWP-1:0] cnt_o,
  output logic [DWP-1:0] load_o,
  output logic [CW-1:0]  ctrl_o,
  output logic           ris_o,
  output logic           irq_o
);
  localparam int unsigned HALF = DWP / 2;

  logic [DWP-1:0] cnt_q, load_q, cnt_d, span, cur, wrap;
  logic [CW-1:0]  ctrl_q;
  logic           ris_q;
  logic           ld_wr, bg_wr, ctrl_wr, clr_wr;
  logic           stick, step, at_zero, hit_one;

  assign ld_wr   = wr_i && (sel_i == REG_LOAD);
  assign bg_wr   = wr_i && (sel_i == REG_BGLD);
  assign ctrl_wr = wr_i && (sel_i == REG_CTRL);
  assign clr_wr  = wr_i && (sel_i == REG_ICLR);

  dual_timer_prescaler #(.PW(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctrl_wr),
    .tick_i  (tick_i),
    .mode_i  (ctrl_q[CB_PS +: 2]),
    .stick_o (stick)
  );

  assign step    = stick && ctrl_q[CB_EN];
  assign span    = ctrl_q[CB_WIDE] ? {DWP{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign cur     = cnt_q & span;
  assign at_zero = (cur == '0);
  assign hit_one = (cur == DWP'(1));

  always_comb begin
    if (ctrl_q[CB_ONESHOT])       wrap = '0;
    else if (ctrl_q[CB_PERIODIC]) wrap = load_q & span;
    else                          wrap = span;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (ld_wr)     cnt_d = wdata_i;
    else if (step) cnt_d = at_zero ? wrap : (cur - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      load_q <= '0;
      ctrl_q <= CTRL_RST;
      ris_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld_wr || bg_wr) load_q <= wdata_i;
      if (ctrl_wr)        ctrl_q <= wdata_i[CW-1:0];
      if (step && hit_one) ris_q <= 1'b1;   // set wins over clear
      else if (clr_wr)     ris_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
  assign ris_o  = ris_q;
  assign irq_o  = ris_q && ctrl_q[CB_IE];
endmodule

// File: rtl/dual_timer_decode.sv
module dual_timer_decode
  import dual_timer_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  output logic [NT-1:0]     wr_o,
  output logic [TIDX_W-1:0] tsel_o,
  output reg_sel_e          sel_o,
  output logic              in_timer_o,
  output logic              in_id_o,
  output logic [2:0]        id_idx_o
);
  localparam logic [AW-SLOT_LSB-1:0] ID_TAG = '1;   // last slot of the window

  assign in_timer_o = (addr_i[AW-1:WIN_LSB] == '0);
  assign tsel_o     = addr_i[SLOT_LSB +: TIDX_W];
  assign sel_o      = reg_sel_e'(addr_i[SLOT_LSB-1:2]);
  assign in_id_o    = (addr_i[AW-1:SLOT_LSB] == ID_TAG);
  assign id_idx_o   = addr_i[SLOT_LSB-1:2];

  for (genvar k = 0; k < NT; k++) begin : g_wr
    assign wr_o[k] = req_i && we_i && in_timer_o && (tsel_o == TIDX_W'(k));
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick0_i,
  input  logic          tick1_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NT-1:0]          tick_w, wr_w, ris_w, irq_w;
  logic [NT-1:0][DW-1:0]  cnt_w, load_w;
  logic [NT-1:0][CW-1:0]  ctrl_w;
  logic [TIDX_W-1:0]      tsel_w;
  reg_sel_e               sel_w;
  logic                   in_timer_w, in_id_w;
  logic [2:0]             id_idx_w;

  assign tick_w = {tick1_i, tick0_i};

  dual_timer_decode u_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wr_o       (wr_w),
    .tsel_o     (tsel_w),
    .sel_o      (sel_w),
    .in_timer_o (in_timer_w),
    .in_id_o    (in_id_w),
    .id_idx_o   (id_idx_w)
  );

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    dual_timer_core #(.DWP(DW)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_w[k]),
      .wr_i    (wr_w[k]),
      .sel_i   (sel_w),
      .wdata_i (wdata_i),
      .cnt_o   (cnt_w[k]),
      .load_o  (load_w[k]),
      .ctrl_o  (ctrl_w[k]),
      .ris_o   (ris_w[k]),
      .irq_o   (irq_w[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (in_timer_w) begin
        case (sel_w)
          REG_LOAD, REG_BGLD: rdata_o = load_w[tsel_w];
          REG_COUNT:          rdata_o = cnt_w[tsel_w];
          REG_CTRL:           rdata_o = {{(DW-CW){1'b0}}, ctrl_w[tsel_w]};
          REG_RAW:            rdata_o = DW'(ris_w[tsel_w]);
          REG_MSK:            rdata_o = DW'(irq_w[tsel_w]);
          default:            rdata_o = '0;
        endcase
      end else if (in_id_w) begin
        rdata_o = DW'(id_byte(id_idx_w));
      end
    end
  end

  assign irq_o = |irq_w;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         rdata_o,
  input logic                  irq_o,
  input logic [NT-1:0]         wr_w,
  input reg_sel_e              sel_w,
  input logic [NT-1:0][DW-1:0] cnt_w,
  input logic [NT-1:0][DW-1:0] load_w,
  input logic [NT-1:0][CW-1:0] ctrl_w,
  input logic [NT-1:0]         ris_w
);
  for (genvar k = 0; k < NT; k++) begin : g_chk
    p_disabled_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_w[k][CB_EN] && !wr_w[k]) |=> $stable(cnt_w[k]));

    p_oneshot_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_w[k][CB_EN] && ctrl_w[k][CB_ONESHOT] && cnt_w[k] == '0 && !wr_w[k])
      |=> cnt_w[k] == '0);

    p_raw_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ris_w[k] && !(wr_w[k] && sel_w == REG_ICLR)) |=> ris_w[k]);

    p_clear_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_w[k] && sel_w == REG_ICLR && !ctrl_w[k][CB_EN]) |=> !ris_w[k]);
  end

  p_irq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ris_w[0] && ctrl_w[0][CB_IE]) || (ris_w[1] && ctrl_w[1][CB_IE])));

  p_id_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 12'hFFC) |-> rdata_o == 32'h0000_00B1);

  p_test_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == 12'hF00 || addr_i == 12'hF04)) |-> rdata_o == '0);

  p_far_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[AW-1:WIN_LSB] != '0) |=> ($stable(load_w) && $stable(ctrl_w)));
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .wr_w    (wr_w),
  .sel_w   (sel_w),
  .cnt_w   (cnt_w),
  .load_w  (load_w),
  .ctrl_w  (ctrl_w),
  .ris_w   (ris_w)
);

// File: tb/test_dual_timer.sv
`timescale 1ns/1ps
module test_dual_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick0_i = 1'b0, tick1_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  logic [7:0] id_exp [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #5 clk_i = ~clk_i;

  dual_timer i_dual_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick0_i (tick0_i),
    .tick1_i (tick1_i),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rdata_o;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    step();
    req_i = 1'b0;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    sb_item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    step();
  endtask

  task automatic tick(input bit t1, input int n);
    for (int i = 0; i < n; i++) begin
      if (t1) tick1_i = 1'b1; else tick0_i = 1'b1;
      step();
      tick0_i = 1'b0; tick1_i = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();

    // reset state
    rd(12'h008, 32'h20, "R3 ctrl reset");
    rd(12'h000, 32'h0, "R3 load reset");
    rd(12'h004, 32'hFFFF_FFFF, "R3 count reset");
    rd(12'h028, 32'h20, "R1 timer1 ctrl reset");
    chk_irq(1'b0, "R8 irq reset");

    // identification and empty offsets
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4*i), {24'b0, id_exp[i]}, "R9 id byte");
    rd(12'hF00, 32'h0, "R10 test ctrl");
    rd(12'hF04, 32'h0, "R10 test out");
    rd(12'h01C, 32'h0, "R2 hole 0x1C");
    rd(12'h040, 32'h0, "R10 past timers");
    rd(12'h800, 32'h0, "R10 mid window");

    // periodic, 32-bit, /1, irq enabled
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE2);
    tick(0, 2);
    rd(12'h004, 32'd1, "R4 decrement");
    chk_irq(1'b0, "R4 not yet zero");
    tick(0, 1);
    rd(12'h004, 32'd0, "R4 reach zero");
    rd(12'h010, 32'd1, "R4 raw flag");
    rd(12'h014, 32'd1, "R8 masked flag");
    chk_irq(1'b1, "R8 irq raised");
    tick(0, 1);
    rd(12'h004, 32'd3, "R5 periodic reload");
    wr(12'h00C, 32'h0);
    rd(12'h010, 32'd0, "R8 clear");
    chk_irq(1'b0, "R8 irq after clear");

    // count write ignored, background load
    wr(12'h004, 32'h1234);
    rd(12'h004, 32'd3, "R2 count write ignored");
    wr(12'h018, 32'd5);
    rd(12'h004, 32'd3, "R2 bg load keeps count");
    rd(12'h000, 32'd5, "R2 bg load value");
    rd(12'h018, 32'd5, "R2 bg load readback");
    tick(0, 4);
    rd(12'h004, 32'd5, "R2 bg value used on reload");
    wr(12'h00C, 32'h0);

    // interrupt masking
    wr(12'h008, 32'hC2);
    tick(0, 5);
    rd(12'h010, 32'd1, "R8 raw with mask off");
    rd(12'h014, 32'd0, "R8 masked off");
    chk_irq(1'b0, "R8 irq masked");

    // timer 1 one-shot on its own tick
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hA3);
    tick(1, 1);
    rd(12'h024, 32'd1, "R7 timer1 ticks");
    rd(12'h004, 32'd0, "R7 timer0 unaffected");
    tick(1, 1);
    chk_irq(1'b1, "R8 merged timer1");
    tick(1, 3);
    rd(12'h024, 32'd0, "R5 one-shot holds");
    rd(12'h030, 32'd1, "R1 timer1 raw");
    wr(12'h008, 32'hE2);
    wr(12'h02C, 32'h0);
    chk_irq(1'b1, "R8 timer0 still pending");
    rd(12'h030, 32'd0, "R1 timer1 cleared");
    wr(12'h00C, 32'h0);
    chk_irq(1'b0, "R8 both cleared");

    // writes outside timer range
    wr(12'h040, 32'hDEAD);
    wr(12'hF00, 32'h1);
    wr(12'hFE0, 32'h7);
    rd(12'h000, 32'd5, "R10 t0 load intact");
    rd(12'h020, 32'd2, "R10 t1 load intact");
    rd(12'hFE0, 32'h04, "R10 id intact");

    // disabled
    wr(12'h008, 32'h62);
    wr(12'h000, 32'd9);
    tick(0, 4);
    rd(12'h004, 32'd9, "R11 disabled hold");

    // free-running 16-bit and 32-bit
    wr(12'h000, 32'd1);
    wr(12'h008, 32'h80);
    tick(0, 1);
    rd(12'h004, 32'd0, "R4 16-bit to zero");
    tick(0, 1);
    rd(12'h004, 32'h0000_FFFF, "R5 16-bit wrap");
    tick(0, 1);
    rd(12'h004, 32'h0000_FFFE, "R4 16-bit decrement");
    wr(12'h000, 32'd0);
    wr(12'h008, 32'h82);
    tick(0, 1);
    rd(12'h004, 32'hFFFF_FFFF, "R5 32-bit wrap");

    // prescaler
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hC6);
    tick(0, 15);
    rd(12'h004, 32'd2, "R6 /16 before edge");
    tick(0, 1);
    rd(12'h004, 32'd1, "R6 /16 on edge");
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hCA);
    tick(0, 255);
    rd(12'h004, 32'd2, "R6 /256 before edge");
    tick(0, 1);
    rd(12'h004, 32'd1, "R6 /256 on edge");
    tick(0, 16);
    rd(12'h004, 32'd1, "R6 /256 not /16");
    wr(12'h008, 32'hCE);
    tick(0, 1);
    rd(12'h004, 32'd0, "R6 code 3 is /1");

    step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule